// File: doc/BRIEF.md
# Programmable-Polynomial GF(2^8) Multiplier

This block multiplies two 8-bit elements of a binary extension field whose defining polynomial is chosen at run time. The field is set by an 8-bit polynomial input that holds the low coefficients of a degree-8 modulus; the x^8 term is always implied. A value of 0x1B on that input selects the field used by the common block cipher, and any other value selects a different field of the same size. The operands must come from a field whose modulus is irreducible for the result to be a true field product. The block does not check this.

Inside, the operands first meet in a carry-less product stage that gives a 15-bit polynomial. A fold stage then removes bits 14 down to 8, highest first. For each bit that is still set, the full modulus shifted to that position is XORed in. A second lane, built the same way, squares the first operand, so one call gives both the product and the square that table generators need. The outputs can be registered (the default) or taken straight from the logic, as a parameter selects.

Top module: `gf_poly_mul`

## Requirements
- R1: `prod` equals the carry-less product of `op_a` and `op_b` reduced modulo x^8 + `poly` (bit i of `poly` is the coefficient of x^i), for every value of `poly`.
- R2: With `poly` = 0x1B, operands 0x57 and 0x83 give `prod` = 0xC1.
- R3: If either operand is 0x01, `prod` equals the other operand.
- R4: If either operand is 0x00, `prod` is 0x00.
- R5: Swapping `op_a` and `op_b` leaves `prod` unchanged.
- R6: `sq` equals `op_a` multiplied by itself under the same `poly`, so `sq` equals `prod` whenever the operands are equal.
- R7: With OUT_REG = 1, `prod` and `sq` change only on a rising clock edge and hold the result for the inputs present at that edge. A cycle with `rst` high makes both 0x00 at the next edge.
- R8: Operands 0x80 and 0x02 give `prod` = `poly`, because x^8 folds to the low polynomial. Operands 0x80 and 0x80 exercise the fold of bit 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset; clears the outputs |
| op_a | input | 8 | First operand; also the operand that is squared |
| op_b | input | 8 | Second operand |
| poly | input | 8 | Low eight coefficients of the modulus (x^8 implied) |
| prod | output | 8 | Field product of `op_a` and `op_b` |
| sq | output | 8 | Field square of `op_a` |

## Verification
The assertions take the inputs to be driven to 0 or 1 at every clock edge. They pair each output with the operands and modulus captured one edge earlier, which holds only when `OUT_REG` is 1 or when the inputs are stable around the edge. They make no claim that `poly` is irreducible: the identity, zero, square-equality and x^8 properties hold for any modulus. The stimulus therefore draws `poly` freely, changes the inputs only on the falling edge, and keeps reset high for several whole cycles.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    localparam int unsigned GF_W  = 8;
    localparam int unsigned GF_PW = 2 * GF_W - 1;
    localparam int unsigned GF_LANES = 2;

    typedef logic [GF_W-1:0]  gf_elem_t;
    typedef logic [GF_PW-1:0] gf_wide_t;

    // Lane 0 carries the general product, lane 1 the square of op_a.
    typedef enum logic [0:0] {
        LANE_MUL = 1'b0,
        LANE_SQR = 1'b1
    } gf_lane_e;

    typedef struct packed {
        gf_elem_t prod;
        gf_elem_t sq;
    } gf_out_t;

    // Full modulus with the implied top coefficient, widened to product width.
    function automatic gf_wide_t gf_modulus(input gf_elem_t low);
        gf_wide_t m;
        m = '0;
        m[GF_W-1:0] = low;
        m[GF_W]     = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gf_clmul.sv
module gf_clmul #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-2:0]   c
);
    localparam int unsigned PW = 2 * W - 1;

    logic [PW-1:0] part [W];

    for (genvar i = 0; i < W; i++) begin : g_part
        logic [PW-1:0] a_ext;
        assign a_ext   = {{(PW-W){1'b0}}, a};
        assign part[i] = b[i] ? (a_ext << i) : '0;
    end

    always_comb begin
        c = '0;
        for (int i = 0; i < W; i++) begin
            c = c ^ part[i];
        end
    end

endmodule

// File: rtl/gf_reduce.sv
module gf_reduce #(
    parameter int unsigned W = 8
) (
    input  logic [2*W-2:0]   c,
    input  logic [W-1:0]     poly,
    output logic [W-1:0]     r
);
    localparam int unsigned PW    = 2 * W - 1;
    localparam int unsigned STEPS = PW - W;

    logic [PW-1:0] fmod;
    logic [PW-1:0] stage [STEPS+1];

    assign fmod     = {{(PW-W-1){1'b0}}, 1'b1, poly};
    assign stage[0] = c;

    // Step s clears bit (PW-1-s) by adding the modulus aligned under it.
    for (genvar s = 0; s < STEPS; s++) begin : g_fold
        localparam int unsigned K  = PW - 1 - s;
        localparam int unsigned SH = K - W;
        logic [PW-1:0] term;
        assign term         = {PW{stage[s][K]}} & (fmod << SH);
        assign stage[s + 1] = stage[s] ^ term;
    end

    assign r = stage[STEPS][W-1:0];

endmodule

// File: rtl/gf_outreg.sv
module gf_outreg #(
    parameter int unsigned W  = 16,
    parameter bit          EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (EN) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end
    end else begin : g_wire
        assign q = d;
    end

endmodule

// File: rtl/gf_poly_mul.sv
module gf_poly_mul
    import gfm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GF_W-1:0]  op_a,
    input  logic [GF_W-1:0]  op_b,
    input  logic [GF_W-1:0]  poly,
    output logic [GF_W-1:0]  prod,
    output logic [GF_W-1:0]  sq
);
    localparam int unsigned OUT_BITS = $bits(gf_out_t);

    gf_elem_t lane_x [GF_LANES];
    gf_elem_t lane_y [GF_LANES];
    gf_elem_t lane_r [GF_LANES];
    gf_wide_t lane_c [GF_LANES];

    gf_out_t  comb_out;
    gf_out_t  reg_out;

    assign lane_x[LANE_MUL] = op_a;
    assign lane_y[LANE_MUL] = op_b;
    assign lane_x[LANE_SQR] = op_a;
    assign lane_y[LANE_SQR] = op_a;

    for (genvar l = 0; l < GF_LANES; l++) begin : g_lane
        gf_clmul #(.W(GF_W)) u_clmul (
            .a (lane_x[l]),
            .b (lane_y[l]),
            .c (lane_c[l])
        );
        gf_reduce #(.W(GF_W)) u_reduce (
            .c    (lane_c[l]),
            .poly (poly),
            .r    (lane_r[l])
        );
    end

    assign comb_out.prod = lane_r[LANE_MUL];
    assign comb_out.sq   = lane_r[LANE_SQR];

    gf_outreg #(.W(OUT_BITS), .EN(OUT_REG)) u_outreg (
        .clk (clk),
        .rst (rst),
        .d   (comb_out),
        .q   (reg_out)
    );

    assign prod = reg_out.prod;
    assign sq   = reg_out.sq;

endmodule

// File: rtl/gf_poly_mul_chk.sv
module gf_poly_mul_chk
    import gfm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [GF_W-1:0]  op_a,
    input logic [GF_W-1:0]  op_b,
    input logic [GF_W-1:0]  poly,
    input logic [GF_W-1:0]  prod,
    input logic [GF_W-1:0]  sq
);
    gf_elem_t cap_a, cap_b, cap_p;
    logic     seen;

    if (OUT_REG) begin : g_cap_reg
        always_ff @(posedge clk) begin
            cap_a <= op_a;
            cap_b <= op_b;
            cap_p <= poly;
            seen  <= !rst;
        end

        // R7: reset clears both outputs at the next edge
        p_reset_clear_r7: assert property (@(posedge clk)
            rst |=> (prod == '0 && sq == '0));
    end else begin : g_cap_wire
        assign cap_a = op_a;
        assign cap_b = op_b;
        assign cap_p = poly;
        assign seen  = 1'b1;
    end

    p_identity_r3: assert property (@(posedge clk) disable iff (rst)
        (seen && cap_b == 8'h01) |-> (prod == cap_a));

    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && (cap_a == 8'h00 || cap_b == 8'h00)) |-> (prod == 8'h00));

    p_square_match_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && cap_a == cap_b) |-> (sq == prod));

    p_known_pair_r2: assert property (@(posedge clk) disable iff (rst)
        (seen && cap_a == 8'h57 && cap_b == 8'h83 && cap_p == 8'h1B) |-> (prod == 8'hC1));

    p_top_fold_r8: assert property (@(posedge clk) disable iff (rst)
        (seen && cap_a == 8'h80 && cap_b == 8'h02) |-> (prod == cap_p));

endmodule

bind gf_poly_mul gf_poly_mul_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/gf_poly_mul_bench.sv
module gf_poly_mul_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_a = 8'h00;
    logic [7:0] op_b = 8'h00;
    logic [7:0] poly = 8'h1B;
    logic [7:0] prod;
    logic [7:0] sq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gf_poly_mul #(.OUT_REG(1'b1)) u_gf_poly_mul (
        .clk  (clk),
        .rst  (rst),
        .op_a (op_a),
        .op_b (op_b),
        .poly (poly),
        .prod (prod),
        .sq   (sq)
    );

    // Shift-and-add model: double the multiplicand each step, folding x^8.
    function automatic int ref_mul(input int a, input int b, input int p);
        int acc = 0;
        int x   = a & 255;
        for (int i = 0; i < 8; i++) begin
            if (((b >> i) & 1) != 0) acc = acc ^ x;
            x = x << 1;
            if ((x & 256) != 0) x = (x & 255) ^ (p & 255);
        end
        return acc & 255;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, then compare at the next falling edge.
    task automatic apply(input int a, input int b, input int p, input string req,
                         output int got);
        int old_prod;
        int exp_prod;
        old_prod = prod;
        exp_prod = ref_mul(a, b, p);
        op_a = 8'(a);
        op_b = 8'(b);
        poly = 8'(p);
        #1;
        if (exp_prod != old_prod) check("R7 hold before edge", prod, old_prod);
        @(negedge clk);
        check(req, prod, exp_prod);
        check("R6 square", sq, ref_mul(a, a, p));
        got = prod;
    endtask

    initial begin
        int g1;
        int g2;
        repeat (3) @(negedge clk);
        check("R7 reset prod", prod, 0);
        check("R7 reset sq", sq, 0);
        rst = 1'b0;

        apply(8'h57, 8'h83, 8'h1B, "R2 known pair", g1);
        apply(8'h83, 8'h57, 8'h1B, "R5 swapped pair", g2);
        check("R5 commute", g2, g1);

        for (int i = 0; i < 6; i++) begin
            int p = (i * 53 + 7) & 255;
            apply(8'h80, 8'h02, p, "R8 x^8 fold", g1);
            check("R8 equals poly", g1, p);
            apply(8'h80, 8'h80, p, "R8 bit14 fold", g1);
        end

        for (int i = 0; i < 8; i++) begin
            int a = (i * 37 + 11) & 255;
            int p = (i * 91 + 3) & 255;
            apply(a, 1, p, "R3 times one", g1);
            check("R3 identity", g1, a);
            apply(1, a, p, "R3 one times", g1);
            apply(a, 0, p, "R4 times zero", g1);
            check("R4 zero", g1, 0);
            apply(0, a, p, "R4 zero times", g1);
        end

        for (int i = 0; i < 150; i++) begin
            int a = $urandom_range(0, 255);
            int b = $urandom_range(0, 255);
            int p = (i % 3 == 0) ? 8'h1B : $urandom_range(0, 255);
            apply(a, b, p, "R1 random product", g1);
            apply(b, a, p, "R1 random swapped", g2);
            check("R5 commute random", g2, g1);
        end

        rst = 1'b1;
        @(negedge clk);
        check("R7 mid-run reset prod", prod, 0);
        check("R7 mid-run reset sq", sq, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule